// File: doc/BRIEF.md
# Table-Driven Memory Control Sequencer

This block produces the control waveforms for one external memory bank from a small table that software loads. Each table entry sets the level of every strobe for exactly one clock cycle: eight byte strobes, four general-purpose lines, a row/column address select, a burst-counter advance flag, a transfer-acknowledge flag and an end-of-sequence flag. A timing change therefore needs no change to the logic. Only the table contents change.

A bus master starts an access with a one-cycle start pulse, an access class and an address. The sequencer jumps to the fixed table entry for that class. It then steps forward one entry per clock and stops after the entry that carries the end flag. The address is captured at the start. The memory address lines carry either its upper half (row) or its lower half with a 2-bit wrapping burst counter in the least significant bits (column). A host write port fills the table while the sequencer is idle.

Top module: `pattern_seq`

## Requirements
- R1: After reset, and whenever the sequencer is idle, the outputs sit at their idle levels: `mem_bs` = 8'hFF, `mem_gpl` = 4'hF, `mem_ack` = 0, `mem_addr` = 0.
- R2: A start pulse sampled at a rising edge while idle selects the first entry by class: `acc_kind` 0 (single read) selects entry 0, 1 (burst read) selects 8, 2 (single write) selects 24, 3 (burst write) selects 32. The levels of that entry appear on the outputs right after that edge.
- R3: While running, each later clock cycle presents the next table entry (index plus one, modulo 64). Entry bits [7:0] drive `mem_bs` and bits [11:8] drive `mem_gpl`.
- R4: An entry with bit 15 (end) set is presented for one cycle. On the following cycle all outputs are back at idle, and a new start is accepted.
- R5: When entry bit 12 is 1, `mem_addr` carries bits [15:8] of the address captured at the start. When bit 12 is 0, `mem_addr` carries the column: captured bits [7:2] above the 2-bit burst counter.
- R6: The burst counter loads captured address bits [1:0] at the start. It advances by one, wrapping from 3 to 0, on each cycle that presents an entry with bit 13 set. The new value is visible from the next cycle.
- R7: `mem_ack` equals entry bit 14 while running and is 0 when idle.
- R8: A host write while idle stores `host_data` at `host_idx`. A later sequence presents the new contents.
- R9: A host write made while a sequence runs leaves the table unchanged.
- R10: A start pulse made while a sequence runs is ignored, and the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_start | input | 1 | One-cycle access start pulse |
| acc_kind | input | 2 | Access class selecting the first table entry |
| acc_addr | input | 16 | Access address, captured at start |
| host_we | input | 1 | Table write strobe |
| host_idx | input | 6 | Table entry index for the write |
| host_data | input | 16 | Table entry contents |
| mem_bs | output | 8 | Byte strobes |
| mem_gpl | output | 4 | General-purpose control lines |
| mem_addr | output | 8 | Multiplexed memory address |
| mem_ack | output | 1 | Transfer acknowledge |

## Verification
The table is filled with entries computed arithmetically. Each entry has a distinct strobe value and its own mix of row-select, advance and acknowledge bits, and the end flags give sequences of 4, 5, 3 and 14 entries. Every access class is run with all four values of the low address bits. This separates a wrong first entry, an off-by-one step and a wrong counter load or wrap: the 14-entry sequence advances the counter past 3 more than once. A changed entry loaded while idle must show up in the next run. A table write and a start pulse issued during a long run must leave that run and the next one unchanged.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  localparam int BS_W  = 8;
  localparam int GPL_W = 4;

  typedef struct packed {
    logic             last;
    logic             ack;
    logic             inc;
    logic             row;
    logic [GPL_W-1:0] gpl;
    logic [BS_W-1:0]  bs;
  } pword_t;

  localparam int WORD_W = $bits(pword_t);

  typedef enum logic [1:0] {
    K_RD_ONE = 2'd0,
    K_RD_BURST = 2'd1,
    K_WR_ONE = 2'd2,
    K_WR_BURST = 2'd3
  } kind_e;

  function automatic int start_of(kind_e k);
    case (k)
      K_RD_ONE:   return 0;
      K_RD_BURST: return 8;
      K_WR_ONE:   return 24;
      default:    return 32;
    endcase
  endfunction
endpackage

// File: rtl/pseq_ram.sv
module pseq_ram #(
  parameter int DEPTH = 64,
  parameter int W     = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/pseq_ctrl.sv
module pseq_ctrl
  import pseq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    kind,
  input  logic          word_last,
  output logic          active,
  output logic          start_fire,
  output logic [IW-1:0] rd_idx
);
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] first_idx;

  assign first_idx  = IW'(start_of(kind_e'(kind)));
  assign start_fire = start && !active;
  // the table read address runs one step ahead of the presented entry
  assign rd_idx     = active ? ptr_q + 1'b1 : first_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      ptr_q  <= '0;
    end else if (start_fire) begin
      active <= 1'b1;
      ptr_q  <= first_idx;
    end else if (active) begin
      if (word_last) active <= 1'b0;
      else           ptr_q  <= ptr_q + 1'b1;
    end
  end

  AST_START_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (start && !active) |=> (active && ptr_q == IW'(start_of(kind_e'($past(kind)))))); // R2
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (active && !word_last) |=> (active && ptr_q == $past(ptr_q) + 1'b1)); // R3
  AST_STOP_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    (active && word_last) |=> !active); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (active && !word_last && start) |=> ptr_q == $past(ptr_q) + 1'b1); // R10
endmodule

// File: rtl/pseq_addr.sv
module pseq_addr #(
  parameter int HALF_W = 8,
  parameter int BEAT_W = 2,
  localparam int AW    = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [AW-1:0]     acc_addr,
  input  logic              run,
  input  logic              inc,
  input  logic              row_sel,
  output logic [HALF_W-1:0] mem_addr
);
  logic [HALF_W-1:0]        row_q;
  logic [HALF_W-BEAT_W-1:0] col_hi_q;
  logic [BEAT_W-1:0]        cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q    <= '0;
      col_hi_q <= '0;
      cnt_q    <= '0;
    end else if (load) begin
      row_q    <= acc_addr[AW-1:HALF_W];
      col_hi_q <= acc_addr[HALF_W-1:BEAT_W];
      cnt_q    <= acc_addr[BEAT_W-1:0];
    end else if (run && inc) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (!run)        mem_addr = '0;
    else if (row_sel) mem_addr = row_q;
    else             mem_addr = {col_hi_q, cnt_q};
  end

  AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (run && inc && !load) |=> cnt_q == $past(cnt_q) + 1'b1); // R6
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!inc && !load) |=> $stable(cnt_q)); // R6
  AST_ROW_KEPT: assert property (@(posedge clk) disable iff (rst)
    (run && !load) |=> $stable(row_q)); // R5
endmodule

// File: rtl/pattern_seq.sv
module pattern_seq
  import pseq_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int HALF_W = 8,
  localparam int IW    = $clog2(DEPTH),
  localparam int AW    = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_start,
  input  logic [1:0]        acc_kind,
  input  logic [AW-1:0]     acc_addr,
  input  logic              host_we,
  input  logic [IW-1:0]     host_idx,
  input  logic [WORD_W-1:0] host_data,
  output logic [BS_W-1:0]   mem_bs,
  output logic [GPL_W-1:0]  mem_gpl,
  output logic [HALF_W-1:0] mem_addr,
  output logic              mem_ack
);
  logic              active;
  logic              start_fire;
  logic [IW-1:0]     rd_idx;
  logic [WORD_W-1:0] rd_data;
  logic              tbl_we;
  pword_t            cur;

  assign tbl_we = host_we && !active;
  assign cur    = pword_t'(rd_data);

  pseq_ram #(.DEPTH(DEPTH), .W(WORD_W)) u_ram (
    .clk(clk), .wr_en(tbl_we), .wr_idx(host_idx), .wr_data(host_data),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  pseq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .start(acc_start), .kind(acc_kind),
    .word_last(cur.last), .active(active), .start_fire(start_fire),
    .rd_idx(rd_idx)
  );

  pseq_addr #(.HALF_W(HALF_W), .BEAT_W(2)) u_addr (
    .clk(clk), .rst(rst), .load(start_fire), .acc_addr(acc_addr),
    .run(active), .inc(cur.inc), .row_sel(cur.row), .mem_addr(mem_addr)
  );

  assign mem_bs  = active ? cur.bs  : '1;
  assign mem_gpl = active ? cur.gpl : '1;
  assign mem_ack = active && cur.ack;

  AST_IDLE_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    (active && cur.last) |=> (mem_bs == '1 && mem_gpl == '1 && !mem_ack && mem_addr == '0)); // R4
endmodule

// File: tb/test_pattern_seq.sv
module test_pattern_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_start = 1'b0;
  logic [1:0]  acc_kind = '0;
  logic [15:0] acc_addr = '0;
  logic        host_we = 1'b0;
  logic [5:0]  host_idx = '0;
  logic [15:0] host_data = '0;
  logic [7:0]  mem_bs;
  logic [3:0]  mem_gpl;
  logic [7:0]  mem_addr;
  logic        mem_ack;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] model [64];

  always #5 clk = ~clk;

  pattern_seq i_pattern_seq (
    .clk(clk), .rst(rst), .acc_start(acc_start), .acc_kind(acc_kind),
    .acc_addr(acc_addr), .host_we(host_we), .host_idx(host_idx),
    .host_data(host_data), .mem_bs(mem_bs), .mem_gpl(mem_gpl),
    .mem_addr(mem_addr), .mem_ack(mem_ack)
  );

  function automatic logic [15:0] pat(int i, int salt);
    logic [7:0] b;
    logic [3:0] g;
    logic       rw, ic, ak, ls;
    b  = 8'(i * 29 + 7 + salt);
    g  = 4'(i ^ salt);
    rw = (i % 3) == 0;
    ic = (i % 2) == 1 || (i % 5) == 0;
    ak = (i % 4) == 2;
    ls = (i == 3) || (i == 12) || (i == 26) || (i == 45);
    return {ls, ak, ic, rw, g, b};
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_chk(string tag);
    chk(tag, {mem_bs, mem_gpl, mem_ack}, {8'hFF, 4'hF, 1'b0});
    chk(tag, {8'h00, mem_addr}, 16'h0000);
  endtask

  task automatic host_wr(int idx, logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_idx = 6'(idx); host_data = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic run(int k, logic [15:0] a, bit disturb, string note);
    int idx;
    int cyc;
    logic [1:0] cnt;
    logic [15:0] w;
    idx = (k == 0) ? 0 : (k == 1) ? 8 : (k == 2) ? 24 : 32;
    cnt = a[1:0];
    cyc = 0;
    @(negedge clk);
    acc_start = 1'b1; acc_kind = 2'(k); acc_addr = a;
    @(negedge clk);
    acc_start = 1'b0;
    acc_addr = ~a;
    forever begin
      w = model[idx];
      chk({(cyc == 0) ? "R2 " : "R3 ", note}, {mem_bs, 4'h0, mem_gpl}, {w[7:0], 4'h0, w[11:8]});
      chk({w[12] ? "R5 " : "R6 ", note}, {8'h00, mem_addr},
          {8'h00, w[12] ? a[15:8] : {a[7:2], cnt}});
      chk({"R7 ", note}, {15'h0, mem_ack}, {15'h0, w[14]});
      if (disturb && cyc == 2) begin
        host_we = 1'b1; host_idx = 6'd40; host_data = ~model[40];
        acc_start = 1'b1; acc_kind = 2'd0; acc_addr = 16'h1234;
      end else begin
        host_we = 1'b0; acc_start = 1'b0;
      end
      if (w[15]) break;
      if (w[13]) cnt = cnt + 2'd1;
      idx = (idx + 1) % 64;
      cyc++;
      @(negedge clk);
    end
    @(negedge clk);
    host_we = 1'b0; acc_start = 1'b0;
    idle_chk({"R4 ", note});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle_chk("R1 reset");
    for (int i = 0; i < 64; i++) begin
      model[i] = pat(i, 0);
      host_wr(i, model[i]);
    end
    idle_chk("R1 idle");
    for (int k = 0; k < 4; k++) begin
      for (int lo = 0; lo < 4; lo++) begin
        run(k, {8'hC0 ^ 8'(k * 17 + lo), 6'(k * 5 + lo * 3), 2'(lo)}, 1'b0, "sweep");
      end
    end
    // R8: reprogram two entries while idle
    model[1] = pat(1, 9);
    host_wr(1, model[1]);
    model[9] = pat(9, 5) | 16'h1000;
    host_wr(9, model[9]);
    run(0, 16'h5A6B, 1'b0, "R8 reload");
    run(1, 16'h0102, 1'b0, "R8 reload");
    // R9, R10: table write and start pulse during a long run
    run(3, 16'h7F3E, 1'b1, "R10 start busy");
    run(3, 16'h7F3E, 1'b0, "R9 write busy");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule